// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing half of a 4096-byte serial memory. It oversamples the clock and data wires of an open-drain two-wire bus with a fast system clock, spots the bus framing conditions, and decodes each transfer a master sends. It serves three operations. A write carries a 12-bit address and then any number of data bytes, each handed to the storage side as a one-cycle write strobe. A random read sets the address through a dummy write, then switches direction with a repeated START. A current-address read continues from wherever the last access left the pointer.

The block drives the data wire only by pulling it low, through a single enable output. The storage array and the timing of programming sit outside. A sequencer outside the block raises a busy input while it programs, and the block then stays completely silent on the bus.

Top module: `twi_mem_slave`

## Requirements
- R1: A high-to-low change of the data wire while the clock wire is high starts a new transfer from any state, including in the middle of a write (repeated START), and the next byte is then decoded as a control byte.
- R2: A low-to-high change of the data wire while the clock wire is high releases the data wire and returns the block to idle; bytes clocked after it are not acknowledged until the next START.
- R3: The control byte is received MSB first as the code 1010, then three select bits, then a direction bit (1 = read). The block pulls the data wire low during the ninth clock only when the code matches and the select bits equal `chip_sel`. Otherwise it gives no acknowledge and ignores the bus until the next START.
- R4: The block changes its pull on the data wire only while the clock wire is low, so an acknowledge stays low through the whole high phase of the ninth clock.
- R5: A write sends a high address byte, whose upper four bits are ignored, then a low address byte. Each following data byte is acknowledged, written at the current address with one `mem_we` pulse, and the address then advances by one.
- R6: While `prog_busy` is high the block acknowledges no byte at all, not even a matching control byte, and it issues no write strobe.
- R7: A random read (dummy write of the address, repeated START, control byte with the read bit) returns the byte stored at that address, MSB first.
- R8: Each byte the master acknowledges during a read is followed by the byte at the next address, across any page boundary. A later read without a new address carries on from the address after the last byte sent.
- R9: The address counter wraps from 0xFFF to 0x000 for both reads and writes.
- R10: When the master does not acknowledge a read byte, the block releases the data wire and does not drive it again until a START.
- R11: During and right after reset the data wire is released and `mem_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock wire as seen at the pad |
| sda_in | input | 1 | Bus data wire as seen at the pad |
| sda_pull_low | output | 1 | 1 = pull the data wire low, 0 = release it |
| chip_sel | input | 3 | Strapped select value compared with the control byte |
| prog_busy | input | 1 | High while the programming sequencer is working |
| mem_addr | output | 12 | Current byte address into the storage |
| mem_we | output | 1 | One-cycle write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Byte to be written |
| mem_rdata | input | 8 | Storage byte at `mem_addr`, valid within a few cycles |

## Verification
Most faults in this block show up first as a missing or unexpected acknowledge, within one byte of the fault. A wrong phase, a select decode error or a busy leak changes the ninth-clock level of the very byte it affects. A wrong address counter or a byte written to the wrong place shows up only in later data bytes. The bench reads these back through random, sequential and wrapping reads, so they surface a whole transfer later at the data wire. Pull changes while the clock wire is high are watched continuously, because such a change would look to other devices like a false START or STOP.

// File: rtl/twi_mem_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the two-wire memory slave.
// Assumes a byte-wide memory and a fixed 4-bit device type code.
package twi_mem_pkg;

    // Which byte of a transfer the slave is currently handling.
    typedef enum logic [2:0] {
        PH_IDLE,   // not addressed: ignore the bus until START
        PH_CTRL,   // receiving the control byte
        PH_AHI,    // receiving the upper address byte
        PH_ALO,    // receiving the lower address byte
        PH_WDATA,  // receiving write data bytes
        PH_TX      // sending read data bytes
    } phase_t;

    localparam int unsigned BYTE_W   = 8;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
// Brings the bus clock and data wires into the system clock domain and flags
// clock edges and START/STOP conditions as one-cycle pulses.
// Assumes the system clock is much faster than the bus clock, so each bus
// level lasts several system cycles. Reset value of both lines is idle-high.
module twi_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_p;
    logic [STAGES-1:0] sda_p;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one extra stage for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_d <= scl_p[LAST];
            sda_d <= sda_p[LAST];
        end
    end

    assign scl_o    = scl_p[LAST];
    assign sda_o    = sda_p[LAST];
    // Edge and bus-condition decode from the last two samples.
    assign scl_rise = scl_o & ~scl_d;
    assign scl_fall = ~scl_o & scl_d;
    assign start_ev = scl_o & scl_d & sda_d & ~sda_o;
    assign stop_ev  = scl_o & scl_d & ~sda_d & sda_o;

endmodule

// File: rtl/twi_addr_ctr.sv
`timescale 1ns/1ps
// Byte address pointer of the memory slave. The two address bytes load the
// upper and lower parts; each read or written byte advances it by one,
// wrapping at the top of the array.
// Assumes ADDR_W is between 9 and 16, so the upper part fits in one byte.
module twi_addr_ctr #(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic [ADDR_W-9:0] hi_val,
    input  logic [7:0]        lo_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] TOP = '1;

    // Pointer register: loads take priority over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_hi) begin
            addr[ADDR_W-1:8] <= hi_val;
        end else if (load_lo) begin
            addr[7:0] <= lo_val;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end

    // R9: the pointer rolls over from the last byte to the first.
    a_r9_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load_hi && !load_lo && addr == TOP) |=> (addr == '0));

endmodule

// File: rtl/twi_mem_slave.sv
`timescale 1ns/1ps
// Bus-side slave of a 4096 x 8 serial memory on an open-drain two-wire bus.
// Decodes control, address and data bytes, strobes writes into the storage
// side and shifts read data out, acknowledging each accepted byte.
// Assumes clk runs at least 8x the bus clock, mem_rdata follows mem_addr
// within a few cycles, and an outside sequencer raises prog_busy while it
// programs the array.
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull_low,
    input  logic [2:0]        chip_sel,
    input  logic              prog_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int unsigned HI_W    = ADDR_W - 8;
    localparam logic [3:0]  ACK_CNT = 4'd8;   // ninth clock slot
    localparam logic [3:0]  END_CNT = 4'd9;   // ninth clock has risen

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    phase_t            phase;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] tx;
    logic              oe;
    logic              ack_q;
    logic              rd_q;
    logic              m_nack;
    logic              we_q;
    logic              ld_hi_q;
    logic              ld_lo_q;
    logic              tx_inc;
    logic              byte_ok;
    logic              ack_ok;

    twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_in),
        .sda_i    (sda_in),
        .scl_o    (scl_s),
        .sda_o    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twi_addr_ctr #(.ADDR_W(ADDR_W)) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (ld_hi_q),
        .load_lo (ld_lo_q),
        .hi_val  (sh[HI_W-1:0]),
        .lo_val  (sh),
        .inc     (we_q | tx_inc),
        .addr    (mem_addr)
    );

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        byte_ok = 1'b1;
        if (phase == PH_CTRL) begin
            byte_ok = (sh[7:4] == DEV_CODE) && (sh[3:1] == chip_sel);
        end
        ack_ok = byte_ok && !prog_busy;
    end

    // Transfer sequencer: bit counting, acknowledge and data-wire control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            tx      <= '0;
            oe      <= 1'b0;
            ack_q   <= 1'b0;
            rd_q    <= 1'b0;
            m_nack  <= 1'b0;
            we_q    <= 1'b0;
            ld_hi_q <= 1'b0;
            ld_lo_q <= 1'b0;
            tx_inc  <= 1'b0;
            mem_wdata <= '0;
        end else begin
            we_q    <= 1'b0;
            ld_hi_q <= 1'b0;
            ld_lo_q <= 1'b0;
            tx_inc  <= 1'b0;
            if (start_ev) begin
                phase   <= PH_CTRL;
                bit_cnt <= '0;
                oe      <= 1'b0;
                ack_q   <= 1'b0;
            end else if (stop_ev) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                oe      <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < ACK_CNT) begin
                        if (phase != PH_TX) sh <= {sh[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (bit_cnt == ACK_CNT) begin
                        bit_cnt <= END_CNT;
                        if (phase == PH_TX) m_nack <= sda_s;
                    end
                end else if (scl_fall) begin
                    if (bit_cnt == ACK_CNT) begin
                        if (phase == PH_TX) begin
                            oe <= 1'b0;
                        end else begin
                            ack_q <= ack_ok;
                            oe    <= ack_ok;
                            if (ack_ok) begin
                                case (phase)
                                    PH_CTRL:  rd_q    <= sh[0];
                                    PH_AHI:   ld_hi_q <= 1'b1;
                                    PH_ALO:   ld_lo_q <= 1'b1;
                                    PH_WDATA: begin
                                        we_q      <= 1'b1;
                                        mem_wdata <= sh;
                                    end
                                    default: ;
                                endcase
                            end
                        end
                    end else if (bit_cnt == END_CNT) begin
                        bit_cnt <= '0;
                        if (phase == PH_TX) begin
                            if (m_nack) begin
                                phase <= PH_IDLE;
                                oe    <= 1'b0;
                            end else begin
                                tx     <= mem_rdata;
                                tx_inc <= 1'b1;
                                oe     <= ~mem_rdata[BYTE_W-1];
                            end
                        end else if (!ack_q) begin
                            phase <= PH_IDLE;
                            oe    <= 1'b0;
                        end else begin
                            oe <= 1'b0;
                            case (phase)
                                PH_CTRL: begin
                                    if (rd_q) begin
                                        phase  <= PH_TX;
                                        tx     <= mem_rdata;
                                        tx_inc <= 1'b1;
                                        oe     <= ~mem_rdata[BYTE_W-1];
                                    end else begin
                                        phase <= PH_AHI;
                                    end
                                end
                                PH_AHI:  phase <= PH_ALO;
                                PH_ALO:  phase <= PH_WDATA;
                                default: phase <= phase;
                            endcase
                        end
                    end else if (phase == PH_TX && bit_cnt != 4'd0) begin
                        oe <= ~tx[3'd7 - bit_cnt[2:0]];
                    end
                end
            end
        end
    end

    assign sda_pull_low = oe;
    assign mem_we       = we_q;

    // R4: the pull on the data wire moves only while the clock wire is low.
    a_r4_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe) |-> !scl_s);

    // R6: no acknowledge is given to a received byte while busy.
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_fall && bit_cnt == ACK_CNT && phase != PH_TX && phase != PH_IDLE
         && prog_busy) |=> !oe);

    // R2: a STOP releases the bus and idles the slave.
    a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (phase == PH_IDLE && !oe));

    // R5: write strobes only come from the data phase of a write.
    a_r5_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (phase == PH_WDATA));

    // R5: each accepted data byte gives exactly one strobe cycle.
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);

    // R10: after a master NACK the slave lets go of the data wire.
    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TX && scl_fall && bit_cnt == END_CNT && m_nack)
        |=> (!oe && phase == PH_IDLE));

endmodule

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
// Self-checking bench: a bit-banged bus master, a byte array as storage,
// and a shadow copy holding the expected contents.
module test_twi_mem_slave;

    localparam int          Q   = 80;          // quarter bus-clock period, ns
    localparam logic [2:0]  SEL = 3'b101;
    localparam int          NV  = 6;
    // Vector fields: {select[2:0], address[11:0], data[7:0], expected ack}
    localparam logic [23:0] VECS [0:NV-1] = '{
        {3'b101, 12'h010, 8'hA5, 1'b1},
        {3'b101, 12'h011, 8'h3C, 1'b1},
        {3'b011, 12'h012, 8'h77, 1'b0},
        {3'b101, 12'hFFF, 8'h81, 1'b1},
        {3'b101, 12'h000, 8'h5A, 1'b1},
        {3'b100, 12'h010, 8'hFF, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [2:0]  chip_sel = SEL;
    logic        prog_busy = 1'b0;
    logic        sda_pull_low;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    wire         sda_line = m_sda & ~sda_pull_low;

    logic [7:0] store [0:4095];
    logic [7:0] model [0:4095];
    logic [7:0] rbuf  [0:7];
    int n_tests = 0;
    int n_fail  = 0;
    int r4_viol = 0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    twi_mem_slave i_twi_mem_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (m_scl),
        .sda_in       (sda_line),
        .sda_pull_low (sda_pull_low),
        .chip_sel     (chip_sel),
        .prog_busy    (prog_busy),
        .mem_addr     (mem_addr),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .mem_rdata    (mem_rdata)
    );

    // Storage model: synchronous write, combinational read.
    always @(posedge clk) if (mem_we) store[mem_addr] <= mem_wdata;
    assign mem_rdata = store[mem_addr];

    // R4 monitor: pull changes while the clock wire is high are violations.
    always @(negedge clk) begin
        if (rst_n && m_scl && sda_pull_low != prev_oe) r4_viol++;
        prev_oe = sda_pull_low;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ctl(input logic [2:0] s, input logic rd);
        return {4'b1010, s, rd};
    endfunction

    task automatic bus_start;
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
        end
        m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; ack = ~sda_line; #Q; m_scl = 1'b0; #Q;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            #Q; m_scl = 1'b1; #Q; b[i] = sda_line; #Q; m_scl = 1'b0;
        end
        #Q; m_sda = ~mack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; m_sda = 1'b1; #Q;
    endtask

    // Random read of n bytes into rbuf; ok is the AND of all slave acks.
    task automatic rd_seq(input logic [11:0] a, input int n, output logic ok);
        logic k0, k1, k2, k3;
        logic [7:0] b;
        bus_start;
        send_byte(ctl(SEL, 1'b0), k0);
        send_byte({4'h0, a[11:8]}, k1);
        send_byte(a[7:0], k2);
        bus_start;
        send_byte(ctl(SEL, 1'b1), k3);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            rbuf[i] = b;
        end
        bus_stop;
        ok = k0 & k1 & k2 & k3;
    endtask

    // Watchdog: a hung run is a failed check and still reports a summary.
    initial begin
        #(10 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic ok, a0, a1, a2, a3, a4;
        logic [7:0] b;
        logic [23:0] v;
        logic [11:0] va;
        for (int i = 0; i < 4096; i++) begin
            store[i] = 8'(i * 7 + 3);
            model[i] = 8'(i * 7 + 3);
        end

        // R11: reset leaves the bus released and no write strobe.
        repeat (10) @(negedge clk);
        chk("R11 pull in reset", {31'd0, sda_pull_low}, 32'd0);
        chk("R11 we in reset", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 pull after reset", {31'd0, sda_pull_low}, 32'd0);

        // R3/R5/R7: vector table of single-byte writes with readback.
        for (int k = 0; k < NV; k++) begin
            v  = VECS[k];
            va = v[20:9];
            bus_start;
            send_byte(ctl(v[23:21], 1'b0), a0);
            send_byte({4'h0, va[11:8]}, a1);
            send_byte(va[7:0], a2);
            send_byte(v[8:1], a3);
            bus_stop;
            chk("R3 control ack", {31'd0, a0}, {31'd0, v[0]});
            chk("R5 address/data acks", {29'd0, a1, a2, a3}, v[0] ? 32'd7 : 32'd0);
            if (v[0]) model[va] = v[8:1];
            rd_seq(va, 1, ok);
            chk("R7 random read acks", {31'd0, ok}, 32'd1);
            chk("R7 random read data", {24'd0, rbuf[0]}, {24'd0, model[va]});
        end

        // R5: multi-byte write, upper nibble of the high address byte ignored.
        bus_start;
        send_byte(ctl(SEL, 1'b0), a0);
        send_byte(8'hF1, a1);
        send_byte(8'h20, a2);
        send_byte(8'h11, a3);
        send_byte(8'h22, a4);
        send_byte(8'h33, ok);
        bus_stop;
        chk("R5 burst acks", {26'd0, a0, a1, a2, a3, a4, ok}, 32'h3F);
        model[12'h120] = 8'h11; model[12'h121] = 8'h22; model[12'h122] = 8'h33;
        rd_seq(12'h120, 3, ok);
        for (int i = 0; i < 3; i++)
            chk("R5 burst readback", {24'd0, rbuf[i]}, {24'd0, model[12'h120 + i]});

        // R8: sequential read across a page boundary, then continue.
        rd_seq(12'h1FD, 5, ok);
        for (int i = 0; i < 5; i++)
            chk("R8 sequential data", {24'd0, rbuf[i]}, {24'd0, model[12'h1FD + i]});
        bus_start;
        send_byte(ctl(SEL, 1'b1), a0);
        recv_byte(1'b0, b);
        bus_stop;
        chk("R8 current address read", {23'd0, a0, b}, {23'd0, 1'b1, model[12'h202]});

        // R9: read pointer wraps from the top of the array to zero.
        rd_seq(12'hFFE, 3, ok);
        chk("R9 wrap byte 0", {24'd0, rbuf[0]}, {24'd0, model[12'hFFE]});
        chk("R9 wrap byte 1", {24'd0, rbuf[1]}, {24'd0, model[12'hFFF]});
        chk("R9 wrap byte 2", {24'd0, rbuf[2]}, {24'd0, model[12'h000]});

        // R6: busy means no acknowledge anywhere and no write.
        prog_busy = 1'b1;
        bus_start;
        send_byte(ctl(SEL, 1'b0), a0);
        send_byte(8'h00, a1);
        send_byte(8'h10, a2);
        send_byte(8'hEE, a3);
        bus_stop;
        prog_busy = 1'b0;
        chk("R6 busy acks", {28'd0, a0, a1, a2, a3}, 32'd0);
        rd_seq(12'h010, 1, ok);
        chk("R6 busy no write", {24'd0, rbuf[0]}, {24'd0, model[12'h010]});

        // R10: after a master NACK the wire stays released.
        bus_start;
        send_byte(ctl(SEL, 1'b1), a0);
        recv_byte(1'b0, b);
        #Q; m_scl = 1'b1; #Q;
        chk("R10 line high after nack", {31'd0, sda_line}, 32'd1);
        #Q; m_scl = 1'b0; #Q;
        chk("R10 no pull after nack", {31'd0, sda_pull_low}, 32'd0);
        bus_stop;

        // R2: a byte after STOP with no START is not acknowledged.
        send_byte(ctl(SEL, 1'b0), a0);
        chk("R2 no ack after stop", {31'd0, a0}, 32'd0);

        // R1: repeated START during a write switches to a read.
        bus_start;
        send_byte(ctl(SEL, 1'b0), a0);
        send_byte(8'h00, a1);
        send_byte(8'h30, a2);
        send_byte(8'h99, a3);
        model[12'h030] = 8'h99;
        bus_start;
        send_byte(ctl(SEL, 1'b1), a4);
        recv_byte(1'b0, b);
        bus_stop;
        chk("R1 write acks", {29'd0, a0, a1, a2}, 32'd7);
        chk("R1 repeated start ack", {31'd0, a4}, 32'd1);
        chk("R1 data after restart", {24'd0, b}, {24'd0, model[12'h031]});
        rd_seq(12'h030, 1, ok);
        chk("R1 write before restart", {24'd0, rbuf[0]}, 32'h99);

        // R4: no pull change was seen while the clock wire was high.
        chk("R4 pull changes with clock high", r4_viol, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule